// File: doc/BRIEF.md
# Synchronous Memory Mode Register Decoder

This block is the device-side control logic that holds the operating-mode word of a synchronous burst-read memory. On every rising clock edge it samples four active-low command strobes (chip select, row strobe, column strobe and a mode-select strobe) and a clock-enable input. When all four strobes are low in one qualified cycle, it takes an 8-bit word from the low address pins as the new mode word.

The word is split into fields: burst length code, burst type, read (column) latency code, row-to-column latency select and a select between array read and identification read. A write starts a fixed three-cycle lockout. During the lockout any command is rejected and flagged. The decoded outputs switch to the new word only when the lockout ends. A mode command issued while a normal access is in progress is refused, and the block records an illegal-state error that only reset clears. The code tables that map field codes to cycle counts belong to the neighbouring logic.

Top module: `mode_reg_ctrl`

## Requirements
- R1: After reset: burst_len_code_o=2'b10 (4 beats), burst_interleave_o=0 (sequential), cas_lat_code_o=3'b101 (5), ras_lat_long_o=0 (2 cycles), id_read_o=0 (array read), busy_o=0, err_o=0.
- R2: A mode write is accepted at a rising edge where cke_i is high at this edge and was high at the previous edge, cs_ni, ras_ni, cas_ni and mr_ni are all low, op_active_i is low and busy_o is low. The word taken is addr_i[7:0] of that cycle.
- R3: Field positions in the accepted word: [1:0] burst length code, [2] burst type (1 = interleaved), [5:3] read latency code, [6] row-to-column latency (1 = 3 cycles, 0 = 2 cycles), [7] read select (1 = identification read).
- R4: busy_o is high for exactly the three cycles that follow the edge that accepts a write.
- R5: The field outputs keep their old values while busy_o is high. They take the new word at the same edge where busy_o falls.
- R6: Any command (cs_ni low in a qualified cycle) sampled while busy_o is high is ignored and sets err_o.
- R7: A mode command sampled while op_active_i is high and busy_o is low is not written, starts no lockout, and sets err_o.
- R8: When cke_i is low at the current edge or was low at the previous edge, no command is sampled: no write and no error.
- R9: err_o stays high once set, until rst_ni is asserted.
- R10: A command with cs_ni low that is not a mode command, sampled while busy_o is low, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low means power-down |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| mr_ni | input | 1 | Mode-select strobe, active low |
| addr_i | input | 8 | Address pins carrying the mode word |
| op_active_i | input | 1 | High while a normal access is in progress |
| busy_o | output | 1 | Lockout window after a write |
| err_o | output | 1 | Sticky protocol / illegal-state error |
| burst_len_code_o | output | 2 | Burst length code |
| burst_interleave_o | output | 1 | Burst type, 1 = interleaved |
| cas_lat_code_o | output | 3 | Read latency code |
| ras_lat_long_o | output | 1 | Row-to-column latency select |
| id_read_o | output | 1 | 1 = identification read, 0 = array read |

## Verification
The bench first writes a word whose fields all differ from the defaults. This shows that each field lands in its bit position, and that the outputs hold until the lockout ends and then switch at the same edge where busy falls. Separate sequences issue a command inside the lockout, a mode command during an access, a mode command in power-down, a mode command in the first cycle after clock-enable returns, and a non-mode command. Each sequence tells apart a dropped command, a refused command that flags an error, and a command that is wrongly taken. A long phase with random strobes, reset pulses and clock-enable drops is compared each cycle against a behavioural model. This exposes errors in window length, qualification and stickiness.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int unsigned WORD_W = 8;

  typedef struct packed {
    logic       id_read;
    logic       ras_long;
    logic [2:0] cas_code;
    logic       interleave;
    logic [1:0] blen_code;
  } mode_word_t;

  // 4-beat, sequential, read latency 5, row-to-column 2, array read
  localparam logic [WORD_W-1:0] MODE_DEFAULT = 8'h2A;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_OTHER = 2'd1,
    CMD_MODE  = 2'd2
  } cmd_e;
endpackage

// File: rtl/mrd_cmd_decode.sv
module mrd_cmd_decode
  import mrd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic mr_ni,
  output cmd_e cmd_o
);
  logic cke_q;
  logic qualified;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  // clock enable must be high at this edge and the one before
  assign qualified = cke_i & cke_q;

  always_comb begin
    cmd_o = CMD_NONE;
    if (qualified && !cs_ni) begin
      if (!ras_ni && !cas_ni && !mr_ni) cmd_o = CMD_MODE;
      else                              cmd_o = CMD_OTHER;
    end
  end

  AST_PD_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |-> cmd_o == CMD_NONE); // R8
endmodule

// File: rtl/mrd_lockout_timer.sv
module mrd_lockout_timer #(
  parameter int unsigned LOCK_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_ONE;
  end

  assign busy_o = (cnt_q != '0);
  // last busy cycle: the next edge ends the window
  assign done_o = (cnt_q == CNT_ONE);

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R6
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R4
  AST_WINDOW_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R4
endmodule

// File: rtl/mrd_mode_store.sv
module mrd_mode_store
  import mrd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              apply_i,
  output mode_word_t        cfg_o
);
  mode_word_t pend_q;
  mode_word_t act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= mode_word_t'(MODE_DEFAULT);
    else if (load_i) pend_q <= mode_word_t'(word_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      act_q <= mode_word_t'(MODE_DEFAULT);
    else if (apply_i) act_q <= pend_q;
  end

  assign cfg_o = act_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(act_q)); // R5
  AST_NO_LOAD_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && apply_i)); // R6
endmodule

// File: rtl/mode_reg_ctrl.sv
module mode_reg_ctrl
  import mrd_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic       cs_ni,
  input  logic       ras_ni,
  input  logic       cas_ni,
  input  logic       mr_ni,
  input  logic [7:0] addr_i,
  input  logic       op_active_i,
  output logic       busy_o,
  output logic       err_o,
  output logic [1:0] burst_len_code_o,
  output logic       burst_interleave_o,
  output logic [2:0] cas_lat_code_o,
  output logic       ras_lat_long_o,
  output logic       id_read_o
);
  cmd_e       cmd;
  logic       busy, done;
  logic       wr_accept;
  logic       err_set;
  logic       err_q;
  mode_word_t cfg;

  mrd_cmd_decode u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_i  (cke_i),
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .mr_ni  (mr_ni),
    .cmd_o  (cmd)
  );

  assign wr_accept = (cmd == CMD_MODE) && !busy && !op_active_i;
  assign err_set   = ((cmd != CMD_NONE) && busy) ||
                     ((cmd == CMD_MODE) && !busy && op_active_i);

  mrd_lockout_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_accept),
    .busy_o  (busy),
    .done_o  (done)
  );

  mrd_mode_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr_accept),
    .word_i  (addr_i),
    .apply_i (done),
    .cfg_o   (cfg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign busy_o             = busy;
  assign err_o              = err_q;
  assign burst_len_code_o   = cfg.blen_code;
  assign burst_interleave_o = cfg.interleave;
  assign cas_lat_code_o     = cfg.cas_code;
  assign ras_lat_long_o     = cfg.ras_long;
  assign id_read_o          = cfg.id_read;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9
  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !wr_accept); // R6
  AST_ACTIVE_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_active_i |-> !wr_accept); // R7
  AST_BUSY_CMD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cke_i && !cs_ni && cmd != CMD_NONE) |=> err_o); // R6
  AST_CFG_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done) |=> $stable(cfg)); // R5
endmodule

// File: tb/tb_mode_reg_ctrl.sv
module tb_mode_reg_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, mr_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic op_act = 1'b0;
  logic busy, err, ileave, ras_long, id_rd;
  logic [1:0] blen;
  logic [2:0] cas;

  int total = 0, bad = 0;
  bit done_flag = 1'b0;

  // reference model state
  int   m_busy_left;
  bit   m_cke_prev, m_err;
  logic [7:0] m_pend, m_cfg;

  always #10 clk = ~clk;

  mode_reg_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .mr_ni(mr_n), .addr_i(addr), .op_active_i(op_act),
    .busy_o(busy), .err_o(err), .burst_len_code_o(blen),
    .burst_interleave_o(ileave), .cas_lat_code_o(cas),
    .ras_lat_long_o(ras_long), .id_read_o(id_rd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] out_word();
    return {id_rd, ras_long, cas, ileave, blen};
  endfunction

  // behavioural model, updated on every edge, compared a quarter period later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy_left = 0; m_cke_prev = 0; m_err = 0;
      m_pend = 8'h2A; m_cfg = 8'h2A;
    end else begin
      bit qual, any, mode;
      qual = cke && m_cke_prev;
      any  = qual && !cs_n;
      mode = any && !ras_n && !cas_n && !mr_n;
      if (m_busy_left > 0) begin
        if (any) m_err = 1;
        m_busy_left--;
        if (m_busy_left == 0) m_cfg = m_pend;
      end else if (mode) begin
        if (op_act) m_err = 1;
        else begin m_pend = addr; m_busy_left = 3; end
      end
      m_cke_prev = cke;
      #5;
      if (rst_n) begin
        chk("R4 busy", busy, m_busy_left != 0);
        chk("R5 cfg", out_word(), m_cfg);
        chk("R9 err", err, m_err);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    cs_n = 1; ras_n = 1; cas_n = 1; mr_n = 1;
  endtask

  task automatic issue(input bit c, input bit r, input bit ca, input bit m, input logic [7:0] a);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; mr_n = m; addr = a;
  endtask

  task automatic after_edge();
    @(posedge clk); #5;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    cs_n = 1; ras_n = 1; cas_n = 1; mr_n = 1; op_act = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; cke = 1;
    #1;
    chk("R1 blen", blen, 2'b10);
    chk("R1 type", ileave, 0);
    chk("R1 cas", cas, 3'b101);
    chk("R1 ras", ras_long, 0);
    chk("R1 id", id_rd, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    idle(); idle();

    // R2/R3/R4/R5: write word with every field changed
    issue(0, 0, 0, 0, 8'hDD);
    after_edge();
    chk("R4 busy c1", busy, 1);
    chk("R5 hold c1", out_word(), 8'h2A);
    idle(); after_edge();
    chk("R4 busy c2", busy, 1);
    after_edge();
    chk("R4 busy c3", busy, 1);
    chk("R5 hold c3", out_word(), 8'h2A);
    after_edge();
    chk("R4 busy end", busy, 0);
    chk("R3 blen", blen, 2'b01);
    chk("R3 type", ileave, 1);
    chk("R3 cas", cas, 3'b011);
    chk("R3 ras", ras_long, 1);
    chk("R3 id", id_rd, 1);
    chk("R2 word", out_word(), 8'hDD);

    // R10: non-mode command outside busy
    issue(0, 1, 0, 1, 8'h00); after_edge();
    chk("R10 busy", busy, 0);
    chk("R10 err", err, 0);
    chk("R10 cfg", out_word(), 8'hDD);
    idle();

    // R6: command during lockout
    issue(0, 0, 0, 0, 8'h11); after_edge();
    issue(0, 0, 0, 0, 8'h77); after_edge();
    chk("R6 err", err, 1);
    idle(); after_edge(); after_edge();
    chk("R6 word kept", out_word(), 8'h11);
    repeat (5) idle();
    chk("R9 sticky", err, 1);
    do_reset(); #1;
    chk("R9 cleared", err, 0);
    chk("R1 after reset", out_word(), 8'h2A);

    // R7: mode command during an access
    idle();
    @(negedge clk); op_act = 1;
    issue(0, 0, 0, 0, 8'h55); after_edge();
    chk("R7 busy", busy, 0);
    chk("R7 err", err, 1);
    idle(); op_act = 0; repeat (4) after_edge();
    chk("R7 cfg", out_word(), 8'h2A);
    do_reset();

    // R8: power-down and first cycle after clock enable returns
    @(negedge clk); cke = 0;
    issue(0, 0, 0, 0, 8'h66); after_edge();
    chk("R8 pd busy", busy, 0);
    chk("R8 pd err", err, 0);
    @(negedge clk); cke = 1;
    after_edge();
    chk("R8 wake busy", busy, 0);
    chk("R8 wake err", err, 0);
    idle(); repeat (4) after_edge();
    chk("R8 cfg", out_word(), 8'h2A);

    // random phase with model compare
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 199) == 0) rst_n = 0; else rst_n = 1;
      cke    = ($urandom_range(0, 9) != 0);
      op_act = ($urandom_range(0, 5) == 0);
      cs_n   = ($urandom_range(0, 2) != 0);
      ras_n  = ($urandom_range(0, 3) == 0);
      cas_n  = ($urandom_range(0, 3) == 0);
      mr_n   = ($urandom_range(0, 3) == 0);
      addr   = 8'($urandom);
    end
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule